// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block takes a clock generator into and out of a low-power state. An asynchronous active-low request, `pd_ni`, is first passed through a synchronizer. When the request lands, the sequencer forces every generated clock low. One cycle later, with the clocks already held low, it turns off the VCO and the crystal oscillator. When the request is withdrawn, it turns the oscillator and the VCO back on together. It then holds the clocks low for a parameterised settling count and only then releases them.

The block runs from an always-on slow clock, so the wake-up timer keeps counting while the main synthesizer clocks are stopped. `SETTLE_CYCLES` is chosen so that the settling time stays below 3 ms at that clock's rate. The default of 80 cycles gives about 2.4 ms at 32.768 kHz. Two stop requests, one for the CPU clock group and one for the bus clock group, are synchronized alongside the power-down request. They gate per-group enables in the running state and have no effect while the clocks are forced low. After power-on reset the sequencer behaves as if it were waking: the oscillator is on and the clocks are held low until the settling count completes.

Top module: `pwrdn_seq`

## Requirements
- R1: `pd_ni`, `cpu_stop_ni` and `bus_stop_ni` each pass through a synchronizer of `SYNC_STAGES` flops that reset to 1. From the running state, a low level on `pd_ni` raises `clk_force_low_o` at the (`SYNC_STAGES`+1)-th rising edge after the change, and not earlier.
- R2: `clk_force_low_o` is high in the cycle before `osc_en_o` and `vco_en_o` fall. Both enables are low only while `clk_force_low_o` is high.
- R3: A power-down request held for at least two synchronized cycles drops `osc_en_o` and `vco_en_o` at the (`SYNC_STAGES`+2)-th edge after `pd_ni` falls.
- R4: In the off state, a high level on `pd_ni` raises `osc_en_o` and `vco_en_o` together at the (`SYNC_STAGES`+1)-th edge, while `clk_force_low_o` stays high.
- R5: After the oscillator is re-enabled, `clk_force_low_o` stays high for exactly `SETTLE_CYCLES` cycles and then falls.
- R6: While `rst_ni` is low: `clk_force_low_o`=1, `osc_en_o`=`vco_en_o`=1, `cpu_clk_en_o`=`bus_clk_en_o`=0. After release with `pd_ni` high, `clk_force_low_o` falls at the `SETTLE_CYCLES`-th edge.
- R7: A synchronized low pulse of one cycle raises `clk_force_low_o` for exactly one cycle and leaves the oscillator and VCO enabled throughout. For a pulse of w ≥ 2 cycles, the oscillator is off for w−1 cycles and `clk_force_low_o` is high for w+`SETTLE_CYCLES` cycles.
- R8: A power-down request arriving during the settling wait turns the oscillator off again, and the next wake waits a full `SETTLE_CYCLES`. If the request arrives in the same cycle as the timer expiry, the request wins and the clocks are never released.
- R9: `cpu_clk_en_o` (or `bus_clk_en_o`) is 1 only in the running state while the synchronized `cpu_stop_ni` (or `bus_stop_ni`) is 1. A stop level change shows on the enable at the `SYNC_STAGES`-th edge. The stop inputs have no effect while `clk_force_low_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on slow clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pd_ni | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_ni | input | 1 | Asynchronous CPU clock-group stop, active low |
| bus_stop_ni | input | 1 | Asynchronous bus clock-group stop, active low |
| clk_force_low_o | output | 1 | Holds every generated clock low when 1 |
| vco_en_o | output | 1 | VCO enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| cpu_clk_en_o | output | 1 | CPU and memory clock group enable |
| bus_clk_en_o | output | 1 | Bus clock group enable |

## Verification
Two functions can meet in one cycle: the wake timer reaching its terminal count, and a new synchronized power-down request arriving. The bench releases `pd_ni` and then drops it again exactly `SETTLE_CYCLES` edges later. The new low level therefore leaves the synchronizer on the terminal edge. The bench judges the outcome by requiring that `clk_force_low_o` never falls and that the oscillator is off right after that edge. A sweep of request widths around the abort case, the short-wait case and the long-wait case compares counted cycles of force-low and oscillator-off against closed-form expectations.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,  // clocks held low, oscillator still on
    ST_OFF  = 2'd2,  // oscillator and VCO off
    ST_WAKE = 2'd3   // oscillator on, settling
  } pwr_state_e;
endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwrdn_timer.sv
module pwrdn_timer #(
  parameter int unsigned SETTLE_CYCLES = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!done_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned SETTLE_CYCLES = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic cpu_stop_ni,
  input  logic bus_stop_ni,
  output logic clk_force_low_o,
  output logic vco_en_o,
  output logic osc_en_o,
  output logic cpu_clk_en_o,
  output logic bus_clk_en_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] async_in, sync_out;
  logic pd_s, cpu_go_s, bus_go_s;
  logic wake_done;
  pwr_state_e state_q, state_d;

  assign async_in = {bus_stop_ni, cpu_stop_ni, pd_ni};

  pwrdn_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NSYNC{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_in),
    .q_o   (sync_out)
  );

  assign pd_s     = sync_out[0];
  assign cpu_go_s = sync_out[1];
  assign bus_go_s = sync_out[2];

  pwrdn_timer #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_WAKE),
    .done_o(wake_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (!pd_s) state_d = ST_HOLD;
      ST_HOLD: state_d = pd_s ? ST_RUN : ST_OFF;
      ST_OFF:  if (pd_s) state_d = ST_WAKE;
      ST_WAKE: begin
        // new request beats timer expiry
        if (!pd_s)          state_d = ST_OFF;
        else if (wake_done) state_d = ST_RUN;
      end
      default: state_d = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAKE;
    else         state_q <= state_d;
  end

  assign clk_force_low_o = (state_q != ST_RUN);
  assign osc_en_o        = (state_q != ST_OFF);
  assign vco_en_o        = (state_q != ST_OFF);
  assign cpu_clk_en_o    = (state_q == ST_RUN) && cpu_go_s;
  assign bus_clk_en_o    = (state_q == ST_RUN) && bus_go_s;
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk
  import pwrdn_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 80
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pd_s,
  input pwr_state_e state_q,
  input logic       clk_force_low_o,
  input logic       vco_en_o,
  input logic       osc_en_o,
  input logic       cpu_clk_en_o,
  input logic       bus_clk_en_o
);
  logic [31:0] on_cnt_q;
  logic        woke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_cnt_q <= '0;
      woke_q   <= 1'b1;
    end else begin
      if (!osc_en_o)                  on_cnt_q <= '0;
      else if (on_cnt_q < SETTLE_CYCLES) on_cnt_q <= on_cnt_q + 1;
      if (!osc_en_o)             woke_q <= 1'b1;
      else if (!clk_force_low_o) woke_q <= 1'b0;
    end
  end

  // R2
  a_r2_off_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o || !vco_en_o) |-> clk_force_low_o);
  a_r2_low_before_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> $past(clk_force_low_o));
  // R1
  a_r1_entry_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !pd_s) |=> clk_force_low_o);
  // R4
  a_r4_wake_held_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> (clk_force_low_o && vco_en_o));
  // R5
  a_r5_settle_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clk_force_low_o) && woke_q) |-> (on_cnt_q >= SETTLE_CYCLES));
  // R8
  a_r8_request_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE && !pd_s) |=> !osc_en_o);
  // R9
  a_r9_enables_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o || bus_clk_en_o) |-> !clk_force_low_o);
endmodule

bind pwrdn_seq pwrdn_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pd_s           (pd_s),
  .state_q        (state_q),
  .clk_force_low_o(clk_force_low_o),
  .vco_en_o       (vco_en_o),
  .osc_en_o       (osc_en_o),
  .cpu_clk_en_o   (cpu_clk_en_o),
  .bus_clk_en_o   (bus_clk_en_o)
);

// File: tb/pwrdn_seq_test.sv
`timescale 1ns/1ps
module pwrdn_seq_test;
  localparam int T = 12;  // settle cycles
  localparam int S = 2;   // sync stages

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pd_ni = 1'b1, cpu_stop_ni = 1'b1, bus_stop_ni = 1'b1;
  logic force_low, vco_en, osc_en, cpu_en, bus_en;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwrdn_seq #(.SYNC_STAGES(S), .SETTLE_CYCLES(T)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni),
    .cpu_stop_ni(cpu_stop_ni), .bus_stop_ni(bus_stop_ni),
    .clk_force_low_o(force_low), .vco_en_o(vco_en), .osc_en_o(osc_en),
    .cpu_clk_en_o(cpu_en), .bus_clk_en_o(bus_en)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int fl_cnt, off_cnt;
    // R6 reset state
    step(3);
    chk("R6 force_low in reset", force_low, 1);
    chk("R6 osc_en in reset", osc_en, 1);
    chk("R6 vco_en in reset", vco_en, 1);
    chk("R6 cpu_en in reset", cpu_en, 0);
    chk("R6 bus_en in reset", bus_en, 0);
    rst_ni = 1'b1;
    step(T - 1);
    chk("R6 still settling", force_low, 1);
    step(1);
    chk("R6 released after settle", force_low, 0);
    chk("R9 cpu_en running", cpu_en, 1);
    chk("R9 bus_en running", bus_en, 1);

    // R1 R2 R3 entry timing
    pd_ni = 1'b0;
    step(S);
    chk("R1 no action before sync", force_low, 0);
    step(1);
    chk("R1 force_low raised", force_low, 1);
    chk("R2 osc still on while held low", osc_en, 1);
    chk("R9 cpu_en gated by force_low", cpu_en, 0);
    step(1);
    chk("R3 osc off", osc_en, 0);
    chk("R3 vco off", vco_en, 0);
    chk("R2 held low while off", force_low, 1);

    // R9 stops are don't-care in power-down
    for (int k = 0; k < 4; k++) begin
      cpu_stop_ni = k[0];
      bus_stop_ni = k[1];
      step(3);
      chk("R9 cpu_en off in power-down", cpu_en, 0);
      chk("R9 bus_en off in power-down", bus_en, 0);
      chk("R9 osc stays off", osc_en, 0);
    end
    cpu_stop_ni = 1'b1;
    bus_stop_ni = 1'b1;

    // R4 R5 exit timing
    pd_ni = 1'b1;
    step(S);
    chk("R4 osc still off before sync", osc_en, 0);
    step(1);
    chk("R4 osc back on", osc_en, 1);
    chk("R4 vco back on", vco_en, 1);
    chk("R4 clocks still low", force_low, 1);
    step(T - 1);
    chk("R5 last settling cycle", force_low, 1);
    step(1);
    chk("R5 clocks released", force_low, 0);

    // R8 request during wait restarts the timer
    pd_ni = 1'b0; step(4); pd_ni = 1'b1; step(S + 1);
    step(5);
    pd_ni = 1'b0; step(S + 1);
    chk("R8 re-entry turns osc off", osc_en, 0);
    pd_ni = 1'b1; step(S + 1);
    chk("R8 osc on again", osc_en, 1);
    step(T - 1);
    chk("R8 full wait after restart", force_low, 1);
    step(1);
    chk("R8 released after full wait", force_low, 0);

    // R8 request arriving on the expiry edge
    pd_ni = 1'b0; step(4); pd_ni = 1'b1; step(S + 1);
    step(T - S - 1);
    pd_ni = 1'b0;
    fl_cnt = 0;
    for (int i = 0; i < S + 1; i++) begin
      step(1);
      if (!force_low) fl_cnt++;
    end
    chk("R8 same-cycle: never released", fl_cnt, 0);
    chk("R8 same-cycle: osc off", osc_en, 0);
    pd_ni = 1'b1; step(S + 1 + T);
    chk("R8 recovers after same-cycle case", force_low, 0);

    // R7 sweep of request widths
    for (int w = 1; w <= T + 4; w++) begin
      fl_cnt = 0; off_cnt = 0;
      pd_ni = 1'b0;
      for (int i = 0; i < w; i++) begin
        step(1);
        fl_cnt += int'(force_low);
        off_cnt += int'(!osc_en);
      end
      pd_ni = 1'b1;
      for (int i = 0; i < T + 8; i++) begin
        step(1);
        fl_cnt += int'(force_low);
        off_cnt += int'(!osc_en);
      end
      chk($sformatf("R7 force_low cycles w=%0d", w), fl_cnt, (w == 1) ? 1 : w + T);
      chk($sformatf("R7 osc off cycles w=%0d", w), off_cnt, w - 1);
      chk($sformatf("R7 back to run w=%0d", w), force_low, 0);
    end

    // R9 stop gating in run
    cpu_stop_ni = 1'b0;
    step(S - 1);
    chk("R9 cpu_en before sync", cpu_en, 1);
    step(1);
    chk("R9 cpu_en stopped", cpu_en, 0);
    chk("R9 bus_en unaffected", bus_en, 1);
    cpu_stop_ni = 1'b1;
    bus_stop_ni = 1'b0;
    step(S);
    chk("R9 cpu_en restarted", cpu_en, 1);
    chk("R9 bus_en stopped", bus_en, 0);
    chk("R9 clocks not forced by stop", force_low, 0);
    bus_stop_ni = 1'b1;
    step(S);
    chk("R9 bus_en restarted", bus_en, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule